// File: doc/BRIEF.md
# Millisecond Interval Timer with Scanned Decimal Display

This block times the gap between two external events. A rising level on the start pin arms a millisecond counter. A high level on the stop pin freezes it. The frozen count stays on a multiplexed four-digit seven-segment display until reset or until the next start edge. Both pins are asynchronous to the system clock, so each one passes through a two-flop synchroniser before any logic uses it.

A prescaler turns the system clock into a single-cycle pulse once per millisecond. Its phase restarts whenever a measurement begins, so the first increment comes exactly one millisecond after the start is taken. The count is split into decimal digits by division and modulus-10. A scanner then shows one digit at a time, rotating through the digits. If the count reaches the largest value the digits can show, it stops there and raises an overrange flag; it does not wrap.

Top module: `interval_timer`

## Requirements
- R1: Each event pin is sampled by two flops in series. A measurement starts only on a 0-to-1 change of the synchronised start pin, so holding that pin high never starts a second measurement.
- R2: A start edge seen while idle or holding clears the count and the overrange flag and begins counting. A start edge seen while counting is ignored.
- R3: The millisecond pulse lasts one clock and repeats every CLK_HZ/TICK_HZ clocks. Its phase restarts on the cycle a start is taken. Each pulse seen while counting adds one to the count.
- R4: A high synchronised stop pin while counting ends the measurement and sets `done_o` to 1. No tick is added in that cycle. The stop pin has no effect while idle or holding.
- R5: While holding, the count does not change until reset or a new start edge.
- R6: The count saturates at 10^DIGITS-1 (9999 by default) and `over_o` goes to 1 instead of wrapping. A new start clears `over_o`.
- R7: Exactly one bit of `dig_en_n_o` is low at any time. Bit i low selects decimal position i, where position 0 is the ones digit. The selection moves from i to i+1, wrapping from the last position to 0, every CLK_HZ/SCAN_HZ clocks.
- R8: `seg_n_o` is active low, with bit 0 = segment a up to bit 6 = segment g. It shows the selected digit (count/10^i) mod 10. The lit-segment codes (active high, g down to a) are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F (hex).
- R9: After reset the block is idle. The count is 0, `done_o` and `over_o` are 0, and position 0 is selected, so the display reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start_i | input | 1 | Asynchronous start event pin |
| ev_stop_i | input | 1 | Asynchronous stop event pin |
| seg_n_o | output | 7 | Active-low segment lines, bit 0 = a .. bit 6 = g |
| dig_en_n_o | output | DIGITS | Active-low digit enables, bit 0 = ones |
| done_o | output | 1 | Measurement finished, result held |
| over_o | output | 1 | Count saturated at full scale |

## Verification
The checker tests the following on every cycle:
- exactly one digit is enabled;
- tick pulses never fall on adjacent cycles;
- the count never decreases while running;
- a held result stays frozen;
- the overrange flag appears only at full scale;
- a synchronised stop during a run always leads to the done state.

Other behaviour shows only over a full scenario. That includes the exact number of milliseconds read back from the scanned display, the two-cycle synchroniser delay, and the fact that a held start pin or a stray stop pin changes nothing. It also includes saturation after a long run and the clearing of the overrange flag on restart. The bench shows these by comparing against a behavioural model and by decoding the display back into a number.

// File: rtl/itm_pkg.sv
// Package: shared state type and the segment encoder for the interval timer.
// Assumes segment bit 0 is segment a and bit 6 is segment g.
package itm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } run_state_t;

    // Active-high lit pattern for one decimal digit; non-decimal codes are blank.
    function automatic logic [6:0] seg_lit(input logic [3:0] d);
        case (d)
            4'd0:    seg_lit = 7'h3F;
            4'd1:    seg_lit = 7'h06;
            4'd2:    seg_lit = 7'h5B;
            4'd3:    seg_lit = 7'h4F;
            4'd4:    seg_lit = 7'h66;
            4'd5:    seg_lit = 7'h6D;
            4'd6:    seg_lit = 7'h7D;
            4'd7:    seg_lit = 7'h07;
            4'd8:    seg_lit = 7'h7F;
            4'd9:    seg_lit = 7'h6F;
            default: seg_lit = 7'h00;
        endcase
    endfunction

endpackage

// File: rtl/itm_sync.sv
// Module: itm_sync
// Brings WIDTH asynchronous pins into the clock domain through two flops
// each, and also provides a third delayed copy so callers can detect edges.
// Assumes the pins are clean (no debouncing is done here).
module itm_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] sync_d_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic s1, s2, s3;
        // Two-stage capture plus one extra delay for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= pin_i[g];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign sync_o[g]   = s2;
        assign sync_d_o[g] = s3;
    end
endmodule

// File: rtl/itm_prescaler.sv
// Module: itm_prescaler
// Produces a one-clock pulse every DIV clocks. A clear input restarts the
// phase so the first pulse after a clear comes DIV clocks later.
// Assumes DIV >= 2.
module itm_prescaler #(
    parameter int DIV = 50_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] phase;

    assign tick_o = (phase == PW'(DIV - 1));

    // Phase counter: restart on clear or at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (clr_i || tick_o)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end
endmodule

// File: rtl/itm_run_ctrl.sv
// Module: itm_run_ctrl
// Idle/run/hold controller with a saturating millisecond counter.
// Assumes start_edge_i and stop_i are already synchronised.
module itm_run_ctrl
    import itm_pkg::*;
#(
    parameter int MAXV = 9999,
    parameter int CW   = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_edge_i,
    input  logic          stop_i,
    input  logic          tick_i,
    output run_state_t    state_o,
    output logic [CW-1:0] count_o,
    output logic          over_o,
    output logic          start_take_o
);
    run_state_t    state;
    logic [CW-1:0] count;
    logic          over;

    // A start edge is only honoured outside a run.
    assign start_take_o = start_edge_i && (state != ST_RUN);

    // State, count and overrange update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            count <= '0;
            over  <= 1'b0;
        end else if (start_take_o) begin
            state <= ST_RUN;
            count <= '0;
            over  <= 1'b0;
        end else if (state == ST_RUN) begin
            if (stop_i) begin
                state <= ST_HOLD;
            end else if (tick_i) begin
                if (count == CW'(MAXV))
                    over <= 1'b1;
                else
                    count <= count + 1'b1;
            end
        end
    end

    assign state_o = state;
    assign count_o = count;
    assign over_o  = over;
endmodule

// File: rtl/itm_scanner.sv
// Module: itm_scanner
// Splits a binary count into decimal digits by divide and modulus-10, then
// rotates through the digits, driving one active-low enable and the
// active-low segments of the selected digit. Assumes SDIV >= 1.
module itm_scanner
    import itm_pkg::*;
#(
    parameter int DIGITS = 4,
    parameter int CW     = 14,
    parameter int SDIV   = 12_500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     count_i,
    output logic [6:0]        seg_n_o,
    output logic [DIGITS-1:0] dig_en_n_o
);
    localparam int SW = (SDIV > 1) ? $clog2(SDIV) : 1;
    localparam int IW = (DIGITS > 1) ? $clog2(DIGITS) : 1;

    logic [3:0]    digit [DIGITS];
    logic [SW-1:0] scnt;
    logic [IW-1:0] idx;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        localparam int P = 10 ** g;
        assign digit[g] = 4'((32'(count_i) / P) % 10);
    end

    // Scan counter and digit index rotation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scnt <= '0;
            idx  <= '0;
        end else if (scnt == SW'(SDIV - 1)) begin
            scnt <= '0;
            idx  <= (idx == IW'(DIGITS - 1)) ? '0 : idx + 1'b1;
        end else begin
            scnt <= scnt + 1'b1;
        end
    end

    // Output decode for the selected digit.
    always_comb begin
        dig_en_n_o = ~(DIGITS'(1) << idx);
        seg_n_o    = ~seg_lit(digit[idx]);
    end
endmodule

// File: rtl/interval_timer.sv
// Module: interval_timer (top)
// Times the span from a start-pin rising edge to a stop-pin assertion in
// milliseconds and shows it on a scanned decimal seven-segment display.
// Assumes CLK_HZ is a multiple of TICK_HZ and of SCAN_HZ.
module interval_timer
    import itm_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int TICK_HZ = 1000,
    parameter int SCAN_HZ = 4000,
    parameter int DIGITS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start_i,
    input  logic              ev_stop_i,
    output logic [6:0]        seg_n_o,
    output logic [DIGITS-1:0] dig_en_n_o,
    output logic              done_o,
    output logic              over_o
);
    localparam int MAXV = 10 ** DIGITS - 1;
    localparam int CW   = $clog2(MAXV + 1);
    localparam int DIV  = CLK_HZ / TICK_HZ;
    localparam int SDIV = CLK_HZ / SCAN_HZ;

    logic [1:0]    pins_s, pins_d;
    logic          start_edge, stop_s, tick, start_take;
    run_state_t    state;
    logic [CW-1:0] ms_count;

    itm_sync #(.WIDTH(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    ({ev_stop_i, ev_start_i}),
        .sync_o   (pins_s),
        .sync_d_o (pins_d)
    );

    assign start_edge = pins_s[0] & ~pins_d[0];
    assign stop_s     = pins_s[1];

    itm_prescaler #(.DIV(DIV)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_take),
        .tick_o (tick)
    );

    itm_run_ctrl #(.MAXV(MAXV), .CW(CW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_edge_i (start_edge),
        .stop_i       (stop_s),
        .tick_i       (tick),
        .state_o      (state),
        .count_o      (ms_count),
        .over_o       (over_o),
        .start_take_o (start_take)
    );

    itm_scanner #(.DIGITS(DIGITS), .CW(CW), .SDIV(SDIV)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_i    (ms_count),
        .seg_n_o    (seg_n_o),
        .dig_en_n_o (dig_en_n_o)
    );

    assign done_o = (state == ST_HOLD);
endmodule

// File: rtl/interval_timer_chk.sv
// Module: interval_timer_chk
// Property checker bound to interval_timer; observes ports and internal
// control signals and never drives anything.
module interval_timer_chk
    import itm_pkg::*;
#(
    parameter int DIGITS = 4,
    parameter int CW     = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DIGITS-1:0] dig_en_n,
    input logic              done,
    input logic              over,
    input run_state_t        state,
    input logic [CW-1:0]     count,
    input logic              tick,
    input logic              stop_s,
    input logic              start_take
);
    localparam int MAXV = 10 ** DIGITS - 1;

    AST_ONE_DIGIT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~dig_en_n) == 1); // R7
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) == ST_RUN) |-> count >= $past(count)); // R6
    AST_SAT_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        over |-> count == CW'(MAXV)); // R6
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !start_take) |=> $stable(count)); // R5
    AST_STOP_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && stop_s) |=> done); // R4
endmodule

bind interval_timer interval_timer_chk #(.DIGITS(DIGITS), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dig_en_n   (dig_en_n_o),
    .done       (done_o),
    .over       (over_o),
    .state      (state),
    .count      (ms_count),
    .tick       (tick),
    .stop_s     (stop_s),
    .start_take (start_take)
);

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
    localparam int CLK_HZ  = 5000;
    localparam int TICK_HZ = 1000;
    localparam int SCAN_HZ = 2500;
    localparam int DIGITS  = 4;
    localparam int DIV     = CLK_HZ / TICK_HZ;
    localparam int SDIV    = CLK_HZ / SCAN_HZ;
    localparam int FULL    = 10 ** DIGITS - 1;

    logic clk = 0, rst_n = 0, a = 0, b = 0;
    logic [6:0] seg_n;
    logic [DIGITS-1:0] dig_n;
    logic done, over;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    interval_timer #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .SCAN_HZ(SCAN_HZ),
                     .DIGITS(DIGITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_start_i(a), .ev_stop_i(b),
        .seg_n_o(seg_n), .dig_en_n_o(dig_n), .done_o(done), .over_o(over));

    // Lit-segment code from R8, active high, g..a.
    function automatic logic [6:0] want_lit(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference model, advanced at every rising edge.
    int  qa[$], qb[$];
    int  m_state, m_cnt, m_phase, m_scnt, m_idx;   // state: 0 idle 1 run 2 hold
    bit  m_over;

    always @(posedge clk) begin
        if (!rst_n) begin
            qa = {0, 0, 0}; qb = {0, 0, 0};
            m_state = 0; m_cnt = 0; m_over = 0; m_phase = 0; m_scnt = 0; m_idx = 0;
        end else begin
            bit rise, stp, tk, take;
            rise = (qa[$-1] == 1) && (qa[$-2] == 0);
            stp  = (qb[$-1] == 1);
            tk   = (m_phase == DIV - 1);
            take = rise && (m_state != 1);
            if (take) begin
                m_state = 1; m_cnt = 0; m_over = 0;
            end else if (m_state == 1) begin
                if (stp) m_state = 2;
                else if (tk) begin
                    if (m_cnt == FULL) m_over = 1; else m_cnt++;
                end
            end
            m_phase = (take || tk) ? 0 : m_phase + 1;
            if (m_scnt == SDIV - 1) begin
                m_scnt = 0; m_idx = (m_idx + 1) % DIGITS;
            end else m_scnt++;
            qa.push_back(int'(a)); qb.push_back(int'(b));
            void'(qa.pop_front()); void'(qb.pop_front());
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int d;
            logic [DIGITS-1:0] e_dig;
            d = (m_cnt / (10 ** m_idx)) % 10;
            e_dig = ~(DIGITS'(1) << m_idx);
            check(dig_n == e_dig, "R7 digit enable", int'(dig_n), int'(e_dig));
            check(seg_n == ~want_lit(d), "R8 segments", int'(seg_n), int'(~want_lit(d)));
            check(done == (m_state == 2), "R4 done", int'(done), int'(m_state == 2));
            check(over == m_over, "R6 over", int'(over), int'(m_over));
        end
    end

    // Decode the scanned display back into a number.
    task automatic read_value(output int val);
        val = 0;
        for (int i = 0; i < DIGITS; i++) begin
            int d;
            for (int w = 0; w < 4 * SDIV * DIGITS && dig_n != ~(DIGITS'(1) << i); w++)
                @(negedge clk);
            d = -1;
            for (int k = 0; k < 10; k++) if (seg_n == ~want_lit(k)) d = k;
            val += d * (10 ** i);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        cycles(4);
        rst_n = 1;
        cycles(1);
        // R9: reset state
        check(done == 0 && over == 0, "R9 flags after reset", int'({done, over}), 0);
        check(dig_n == ~DIGITS'(1), "R9 position 0 selected", int'(dig_n), int'(~DIGITS'(1)));
        check(seg_n == ~7'h3F, "R9 display reads 0", int'(seg_n), int'(~7'h3F));

        // R4: stop pin while idle has no effect
        b = 1; cycles(6); b = 0; cycles(4);
        check(done == 0, "R4 stop ignored in idle", int'(done), 0);

        // R3/R4: 37 ms interval
        a = 1; cycles(37 * DIV + 1); b = 1; cycles(4); b = 0;
        check(done == 1, "R4 done after stop", int'(done), 1);
        read_value(v);
        check(v == 37, "R3 measured ms", v, 37);

        // R5: result held; R4: further stop pulses ignored
        cycles(200); b = 1; cycles(5); b = 0; cycles(5);
        read_value(v);
        check(v == 37, "R5 held result", v, 37);

        // R1: start pin still high, no restart
        check(done == 1, "R1 held start pin does not restart", int'(done), 1);

        // R2: new edge restarts; toggle during run is ignored
        a = 0; cycles(5); a = 1; cycles(3);
        check(done == 0, "R2 restart from hold", int'(done), 0);
        cycles(6 * DIV - 2);
        a = 0; cycles(5); a = 1; cycles(6 * DIV - 5 + 1 - 1);
        b = 1; cycles(4); b = 0;
        read_value(v);
        check(v == 12, "R2 edge during run ignored", v, 12);

        // R6: saturation then clear on restart
        a = 0; cycles(5); a = 1;
        cycles((FULL + 3) * DIV);
        check(over == 1 && done == 0, "R6 saturated and running", int'({over, done}), 2);
        read_value(v);
        check(v == FULL, "R6 saturated value", v, FULL);
        b = 1; cycles(4); b = 0;
        check(done == 1 && over == 1, "R6 stop after saturation", int'({done, over}), 3);
        a = 0; cycles(5); a = 1; cycles(4);
        check(over == 0, "R6 over cleared on restart", int'(over), 0);

        // R9: reset during a run
        cycles(3 * DIV);
        rst_n = 0; cycles(3); rst_n = 1; a = 0; cycles(1);
        read_value(v);
        check(v == 0 && done == 0 && over == 0, "R9 reset mid-run", v, 0);

        cycles(10);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule